// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

This block is a synthesizable, clock-sampled model of a word-organized static memory that sits behind an asynchronous control interface. The interface has an 18-bit word address and active-low controls for chip enable, write enable and output enable, plus one mask per byte lane. From these pins alone the model decides, for each byte lane, whether the lane is driven with stored data, is written, or floats. A bidirectional data pad is split here into a write-data bus, a read-data bus and a per-lane drive flag. A surrounding pad ring or bus fabric turns the flag into a tri-state enable.

The model samples all pins on each rising clock edge. Every output comes from a register. The storage depth is a parameter. Only the low address bits that index the configured depth select a word, so a small array can stand in for the full 256K-word space. A write is committed once, on the clock edge where the internal write strobe first becomes active. That strobe is the AND of three conditions: the chip is selected, write enable is low, and at least one lane is unmasked. A standby flag reports when the part is deselected or both lanes are masked.

Top module: `byte_lane_sram`

## Requirements
- R1: With `ce_n` high, the model is deselected. In the next cycle both bits of `dout_en` are 0 and `standby` is 1, and no word changes, even with `we_n` low.
- R2: With `ce_n` low and both `lb_n` and `ub_n` high, no lane is driven or written in the next cycle, and `standby` is 1.
- R3: With `ce_n` low, `we_n` high and `oe_n` high, both lanes float in the next cycle and `standby` is 0.
- R4: A read is the state with `ce_n` low, `we_n` high and `oe_n` low. In the next cycle, a lane whose mask is low is driven (`dout_en` bit set) with the stored byte of the addressed word. A lane whose mask is high floats.
- R5: A write is the state with `ce_n` low and `we_n` low. It stores only the lanes whose mask is low. Bits 7:0 belong to `lb_n` and `dout_en[0]`. Bits 15:8 belong to `ub_n` and `dout_en[1]`. A masked lane keeps its previous byte.
- R6: During a write, both lanes float in the next cycle and `standby` is 0, whatever the value of `oe_n`.
- R7: A write commits only on the first cycle in which the write strobe is active. If the strobe stays active over later cycles with new data, the stored word does not change.
- R8: A floating lane presents zero on its bits of `dout`.
- R9: In the cycle after a cycle with `rst` high, `dout` is 0, `dout_en` is 0 and `standby` is 1. No write happens while `rst` is high.
- R10: Only the low log2(DEPTH) address bits select a word, so two addresses that differ by DEPTH refer to the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 18 | Word address |
| din | input | 16 | Write data |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low, takes priority over `oe_n` |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lower-lane mask, active low, bits 7:0 |
| ub_n | input | 1 | Upper-lane mask, active low, bits 15:8 |
| dout | output | 16 | Registered read data, zero in floating lanes |
| dout_en | output | 2 | Registered per-lane drive flag, bit 0 lower, bit 1 upper |
| standby | output | 1 | Registered deselect-or-fully-masked flag |

## Verification
Every output is due exactly one clock after the pins that cause it are sampled. A word that is written on one edge becomes visible to a read sampled on any later edge. The bench changes the inputs just after a falling edge, lets one rising edge sample them, and compares at the next falling edge. At that point it has already advanced its own model of the array, of the previous strobe state and of the expected output registers by that one edge. Bytes that were never written are excluded from the data comparison. Drive flags and standby are still compared for those bytes.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    LANE_IDLE  = 2'd0,
    LANE_READ  = 2'd1,
    LANE_WRITE = 2'd2
  } lane_op_e;
endpackage

// File: rtl/lane_ctrl_decode.sv
module lane_ctrl_decode
  import lane_sram_pkg::*;
(
  input  logic     sel,
  input  logic     wr_req,
  input  logic     rd_req,
  input  logic     mask_n,
  output lane_op_e op
);
  always_comb begin
    op = LANE_IDLE;
    if (sel && !mask_n) begin
      if (wr_req)      op = LANE_WRITE;
      else if (rd_req) op = LANE_READ;
    end
  end
endmodule

// File: rtl/lane_sram_array.sv
module lane_sram_array
  import lane_sram_pkg::*;
#(
  parameter int LANES = 2,
  parameter int DEPTH = 1024,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic [LANES-1:0]  lane_we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[idx] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[idx];
  end
endmodule

// File: rtl/lane_sram_outreg.sv
module lane_sram_outreg
  import lane_sram_pkg::*;
#(
  parameter int LANES = 2,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  lane_op_e          op [LANES],
  input  logic [WORD_W-1:0] rdata,
  input  logic              idle_c,
  output logic [WORD_W-1:0] dout,
  output logic [LANES-1:0]  dout_en,
  output logic              standby
);
  for (genvar g = 0; g < LANES; g++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) begin
        dout_en[g] <= 1'b0;
        dout[g*LANE_W +: LANE_W] <= '0;
      end else begin
        dout_en[g] <= (op[g] == LANE_READ);
        dout[g*LANE_W +: LANE_W] <= (op[g] == LANE_READ) ? rdata[g*LANE_W +: LANE_W] : '0;
      end
    end

    assert_float_zero_R8: assert property (@(posedge clk) disable iff (rst)
      !dout_en[g] |-> (dout[g*LANE_W +: LANE_W] == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) standby <= 1'b1;
    else     standby <= idle_c;
  end

  assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    standby |-> (dout_en == '0));
endmodule

// File: rtl/byte_lane_sram.sv
module byte_lane_sram
  import lane_sram_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              lb_n,
  input  logic              ub_n,
  output logic [DATA_W-1:0] dout,
  output logic [1:0]        dout_en,
  output logic              standby
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int IDX_W = $clog2(DEPTH);

  logic [LANES-1:0] mask_n;
  lane_op_e         op [LANES];
  logic [LANES-1:0] lane_wr;
  logic             strobe, strobe_q, commit;
  logic [DATA_W-1:0] rdata;

  assign mask_n = {ub_n, lb_n};

  for (genvar g = 0; g < LANES; g++) begin : g_dec
    lane_ctrl_decode u_dec (
      .sel    (!ce_n),
      .wr_req (!we_n),
      .rd_req (!oe_n),
      .mask_n (mask_n[g]),
      .op     (op[g])
    );
    assign lane_wr[g] = commit && (op[g] == LANE_WRITE);
  end

  assign strobe = !ce_n && !we_n && !(&mask_n);
  assign commit = strobe && !strobe_q && !rst;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  lane_sram_array #(.LANES(LANES), .DEPTH(DEPTH)) u_array (
    .clk     (clk),
    .lane_we (lane_wr),
    .idx     (addr[IDX_W-1:0]),
    .wdata   (din),
    .rdata   (rdata)
  );

  lane_sram_outreg #(.LANES(LANES)) u_out (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .rdata   (rdata),
    .idle_c  (ce_n || (&mask_n)),
    .dout    (dout),
    .dout_en (dout_en),
    .standby (standby)
  );

  assert_deselect_float_R1: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> (dout_en == 2'b00) && standby);

  assert_write_float_R6: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !we_n) |=> (dout_en == 2'b00));

  assert_disabled_float_R3: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && we_n && oe_n) |=> (dout_en == 2'b00));

  assert_read_lane_R4: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && we_n && !oe_n && !lb_n) |=> dout_en[0]);
endmodule

// File: tb/test_byte_lane_sram.sv
module test_byte_lane_sram;
  localparam int CLK_PERIOD = 10;
  localparam int BDEPTH = 64;

  logic clk = 1'b0;
  logic rst;
  logic [17:0] addr;
  logic [15:0] din;
  logic ce_n, we_n, oe_n, lb_n, ub_n;
  logic [15:0] dout;
  logic [1:0]  dout_en;
  logic        standby;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  logic [15:0] ref_mem   [BDEPTH];
  logic [1:0]  ref_known [BDEPTH];
  bit          ref_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_lane_sram #(.ADDR_W(18), .DATA_W(16), .DEPTH(BDEPTH)) i_byte_lane_sram (
    .clk(clk), .rst(rst), .addr(addr), .din(din),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n),
    .dout(dout), .dout_en(dout_en), .standby(standby)
  );

  task automatic step(input bit r, input bit ce, input bit we, input bit oe,
                      input bit lb, input bit ub, input logic [17:0] a,
                      input logic [15:0] d, input string tag);
    logic [1:0]  e_en;
    logic [15:0] e_do;
    logic [1:0]  e_kn;
    bit e_sb, cs, masked, strb, rd;
    int idx;
    rst = r; ce_n = ce; we_n = we; oe_n = oe; lb_n = lb; ub_n = ub; addr = a; din = d;
    idx = int'(a) % BDEPTH;
    e_kn = 2'b11;
    if (r) begin
      e_en = 2'b00; e_do = '0; e_sb = 1; ref_prev = 0;
    end else begin
      cs = !ce; masked = lb && ub;
      e_sb = !cs || masked;
      strb = cs && !we && !masked;
      rd = cs && we && !oe;
      e_en = {rd && !ub, rd && !lb};
      e_do[7:0]  = e_en[0] ? ref_mem[idx][7:0]  : 8'h00;
      e_do[15:8] = e_en[1] ? ref_mem[idx][15:8] : 8'h00;
      e_kn[0] = !e_en[0] || ref_known[idx][0];
      e_kn[1] = !e_en[1] || ref_known[idx][1];
      if (strb && !ref_prev) begin
        if (!lb) begin ref_mem[idx][7:0]  = d[7:0];  ref_known[idx][0] = 1'b1; end
        if (!ub) begin ref_mem[idx][15:8] = d[15:8]; ref_known[idx][1] = 1'b1; end
      end
      ref_prev = strb;
    end
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (dout_en !== e_en || standby !== e_sb ||
        (e_kn[0] && dout[7:0] !== e_do[7:0]) ||
        (e_kn[1] && dout[15:8] !== e_do[15:8])) begin
      errors++;
      $display("FAIL %s: en=%b sb=%b dout=%h expected en=%b sb=%b dout=%h",
               tag, dout_en, standby, dout, e_en, e_sb, e_do);
    end
  endtask

  task automatic idle(input string tag);
    step(0, 0, 1, 1, 0, 0, 18'd0, 16'h0, tag);
  endtask

  task automatic wr(input logic [17:0] a, input logic [15:0] d, input bit lb, input bit ub, input string tag);
    step(0, 0, 0, 1, lb, ub, a, d, tag);
    idle("R3");
  endtask

  task automatic rd(input logic [17:0] a, input bit lb, input bit ub, input string tag);
    step(0, 0, 1, 0, lb, ub, a, 16'h0, tag);
  endtask

  initial begin
    for (int i = 0; i < BDEPTH; i++) begin ref_known[i] = 2'b00; ref_mem[i] = '0; end
    @(negedge clk);
    step(1, 1, 1, 1, 1, 1, 18'd0, 16'h0, "R9");
    step(1, 0, 0, 0, 0, 0, 18'd3, 16'hDEAD, "R9");
    for (int i = 0; i < 8; i++) wr(18'(i), 16'(16'h1111 * (i + 1)), 0, 0, "R5");
    for (int i = 0; i < 8; i++) rd(18'(i), 0, 0, "R4");
    rd(18'd2, 0, 1, "R8");
    rd(18'd5, 1, 0, "R8");
    wr(18'd1, 16'hAB00 | 16'h00CD, 0, 1, "R5");
    rd(18'd1, 0, 0, "R5");
    wr(18'd4, 16'h9A00, 1, 0, "R5");
    rd(18'd4, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 18'd6, 16'h5A5A, "R6");
    idle("R3");
    rd(18'd6, 0, 0, "R6");
    step(0, 0, 0, 1, 0, 0, 18'd7, 16'h0F0F, "R7");
    step(0, 0, 0, 1, 0, 0, 18'd7, 16'hF0F0, "R7");
    step(0, 0, 0, 1, 0, 1, 18'd7, 16'h3333, "R7");
    idle("R3");
    rd(18'd7, 0, 0, "R7");
    step(0, 1, 0, 0, 0, 0, 18'd0, 16'hEEEE, "R1");
    step(0, 1, 1, 0, 0, 0, 18'd0, 16'hEEEE, "R1");
    rd(18'd0, 0, 0, "R1");
    step(0, 0, 0, 0, 1, 1, 18'd3, 16'h7777, "R2");
    step(0, 0, 1, 0, 1, 1, 18'd3, 16'h0, "R2");
    rd(18'd3, 0, 0, "R2");
    wr(18'(BDEPTH + 9), 16'hC3A5, 0, 0, "R10");
    rd(18'd9, 0, 0, "R10");
    rd(18'((BDEPTH * 3) + 9), 0, 0, "R10");
    step(0, 0, 1, 1, 0, 0, 18'd9, 16'h0, "R3");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule